// File: doc/BRIEF.md
# Multi-Stream Time-Slot Allocation Table

This block keeps the time-slot map of a multi-stream transport link. The map has four entries. Each entry names a source stream and the number of link time slots that stream owns. Software fills a staging copy of the map through a simple register write port. It then writes an update command. The block copies the staging copy into the active copy at the next transport packet header. The packing logic reads the active copy continuously.

There are two update commands. One first raises a one-cycle request for the link layer to send an allocation-change control symbol, and then commits. The other commits without that request. The pending command can be read back and clears itself on commit. After each commit a keepout flag stays high until sixteen further packet headers have gone out. Software polls until both the command readback and the keepout flag are zero. Every pin is a plain control or status pin with no handshake: a write is taken in the cycle `wr_en` is high, and `pkt_hdr` is a one-cycle pulse for each header sent.

Top module: `mst_slot_table`

## Requirements
- R1: While reset is held and just after it is released, every active entry reads source 0 and slot count 0, the command readback is 0, keepout is 0 and the trigger request is 0.
- R2: A write to address 0 stages entries 0 (bits 15:0) and 1 (bits 31:16). A write to address 1 stages entries 2 and 3 in the same way. Within each 16-bit half, the source ID is in bits 3:0 and the slot count is in bits 13:8. A staging write never changes the active table by itself.
- R3: Writing command code 1 to address 2 while no command is pending does two things. The trigger request is high for exactly the one cycle after the write. The command readback shows 1 from that cycle until the commit.
- R4: A commit happens at the first packet header sampled after the trigger cycle. A header in the trigger cycle itself is not a commit point. At the commit, the active table takes the staged values and the command readback returns to 0.
- R5: Command code 2 commits at the first packet header sampled after the write, with no trigger request. The readback shows 2 while the command is pending.
- R6: Command codes 0 and 3 do nothing: no trigger, readback stays 0, and the active table is unchanged by later headers.
- R7: A command write while a command is pending is ignored: the readback keeps the pending code and no extra trigger is raised.
- R8: Keepout goes high at each commit. It falls after the sixteenth packet header that follows the commit.
- R9: A staging write in the same cycle as a commit header changes only the staging copy. The active table receives the values staged before that cycle.
- R10: A commit during keepout restarts the sixteen-header count from that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0/1 staging words, 2 command |
| wr_data | input | 32 | Write data |
| pkt_hdr | input | 1 | One-cycle pulse per transport packet header sent |
| upd_status | output | 2 | Pending command code, 0 when idle |
| keepout | output | 1 | High during the post-commit header window |
| trig_req | output | 1 | Request to send an allocation-change control |
| act_src | output | 16 | Active source IDs, entry e at bits 4e+3:4e |
| act_slot | output | 24 | Active slot counts, entry e at bits 6e+5:6e |

## Verification
Two functions can fall in the same cycle. One is a staging write. The other is the header that commits a pending command. The bench forces them together by pulsing `pkt_hdr` in the same cycle as a write to address 0. It then checks that the active table shows the earlier staged values, and that a second commit carries the new ones. It also places a new commit inside a running keepout window. Keepout must then hold for a full sixteen headers from the second commit. A behavioural model judges every clock.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TRIG = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  localparam logic [1:0] CODE_NONE   = 2'd0;
  localparam logic [1:0] CODE_TRIG   = 2'd1;
  localparam logic [1:0] CODE_SILENT = 2'd2;

  localparam int HALF_W   = 16;
  localparam int SLOT_LSB = 8;
endpackage

// File: rtl/sat_stage.sv
module sat_stage #(
  parameter int ENTRIES = 4,
  parameter int SID_W   = 4,
  parameter int SLOT_W  = 6,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [ENTRIES*SID_W-1:0]  stg_src,
  output logic [ENTRIES*SLOT_W-1:0] stg_slot
);
  import sat_pkg::*;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam int WORD = e / 2;
    localparam int LSB  = (e % 2) * HALF_W;
    logic [SID_W-1:0]  src_q;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q  <= '0;
        slot_q <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(WORD)) begin
        src_q  <= wr_data[LSB +: SID_W];
        slot_q <= wr_data[LSB + SLOT_LSB +: SLOT_W];
      end
    end

    assign stg_src[e*SID_W +: SID_W]    = src_q;
    assign stg_slot[e*SLOT_W +: SLOT_W] = slot_q;
  end
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_code,
  input  logic              pkt_hdr,
  output logic              trig_req,
  output logic              commit,
  output logic [1:0]        upd_status
);
  import sat_pkg::*;

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(ENTRIES / 2);

  phase_e     phase_q;
  logic [1:0] code_q;
  logic       cmd_wr;

  assign cmd_wr = wr_en && (wr_addr == CMD_ADDR) && (phase_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      code_q  <= CODE_NONE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (cmd_wr && wr_code == CODE_TRIG) begin
            phase_q <= PH_TRIG;
            code_q  <= CODE_TRIG;
          end else if (cmd_wr && wr_code == CODE_SILENT) begin
            phase_q <= PH_WAIT;
            code_q  <= CODE_SILENT;
          end
        end
        PH_TRIG: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (pkt_hdr) begin
            phase_q <= PH_IDLE;
            code_q  <= CODE_NONE;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          code_q  <= CODE_NONE;
        end
      endcase
    end
  end

  assign trig_req   = (phase_q == PH_TRIG);
  assign commit     = (phase_q == PH_WAIT) && pkt_hdr;
  assign upd_status = code_q;
endmodule

// File: rtl/sat_keepout.sv
module sat_keepout #(
  parameter int HDR_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic pkt_hdr,
  output logic keepout
);
  localparam int CNT_W = (HDR_N > 1) ? $clog2(HDR_N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ko_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ko_q  <= 1'b0;
      cnt_q <= '0;
    end else if (commit) begin
      ko_q  <= 1'b1;
      cnt_q <= '0;
    end else if (ko_q && pkt_hdr) begin
      if (cnt_q == LAST) begin
        ko_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign keepout = ko_q;
endmodule

// File: rtl/sat_active.sv
module sat_active #(
  parameter int ENTRIES = 4,
  parameter int SID_W   = 4,
  parameter int SLOT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [ENTRIES*SID_W-1:0]  stg_src,
  input  logic [ENTRIES*SLOT_W-1:0] stg_slot,
  output logic [ENTRIES*SID_W-1:0]  act_src,
  output logic [ENTRIES*SLOT_W-1:0] act_slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_src  <= '0;
      act_slot <= '0;
    end else if (commit) begin
      act_src  <= stg_src;
      act_slot <= stg_slot;
    end
  end
endmodule

// File: rtl/mst_slot_table.sv
module mst_slot_table #(
  parameter int ENTRIES = 4,
  parameter int SID_W   = 4,
  parameter int SLOT_W  = 6,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  parameter int HDR_N   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      pkt_hdr,
  output logic [1:0]                upd_status,
  output logic                      keepout,
  output logic                      trig_req,
  output logic [ENTRIES*SID_W-1:0]  act_src,
  output logic [ENTRIES*SLOT_W-1:0] act_slot
);
  logic [ENTRIES*SID_W-1:0]  stg_src;
  logic [ENTRIES*SLOT_W-1:0] stg_slot;
  logic                      commit;

  sat_stage #(.ENTRIES(ENTRIES), .SID_W(SID_W), .SLOT_W(SLOT_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg_src(stg_src), .stg_slot(stg_slot)
  );

  sat_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_code(wr_data[1:0]), .pkt_hdr(pkt_hdr), .trig_req(trig_req),
    .commit(commit), .upd_status(upd_status)
  );

  sat_keepout #(.HDR_N(HDR_N)) u_ko (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pkt_hdr(pkt_hdr),
    .keepout(keepout)
  );

  sat_active #(.ENTRIES(ENTRIES), .SID_W(SID_W), .SLOT_W(SLOT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .commit(commit), .stg_src(stg_src),
    .stg_slot(stg_slot), .act_src(act_src), .act_slot(act_slot)
  );
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int ENTRIES = 4,
  parameter int SID_W   = 4,
  parameter int SLOT_W  = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pkt_hdr,
  input logic [1:0]                upd_status,
  input logic                      keepout,
  input logic                      trig_req,
  input logic [ENTRIES*SID_W-1:0]  act_src,
  input logic [ENTRIES*SLOT_W-1:0] act_slot
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |=> !trig_req); // R3
  AST_TRIG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |-> upd_status == 2'd1); // R3
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_status == 2'd0 |=> ($stable(act_src) && $stable(act_slot))); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    upd_status != 2'd3); // R6
  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_status != 2'd0 && !pkt_hdr) |=> $stable(upd_status)); // R7
  AST_KO_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keepout) |-> ($past(upd_status) != 2'd0 && upd_status == 2'd0)); // R8
endmodule

bind mst_slot_table sat_checker #(.ENTRIES(ENTRIES), .SID_W(SID_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_hdr(pkt_hdr), .upd_status(upd_status),
  .keepout(keepout), .trig_req(trig_req), .act_src(act_src), .act_slot(act_slot)
);

// File: tb/sim_mst_slot_table.sv
module sim_mst_slot_table;
  localparam int NE = 4;
  localparam int SW = 4;
  localparam int LW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pkt_hdr = 1'b0;
  logic [1:0]  upd_status;
  logic        keepout;
  logic        trig_req;
  logic [15:0] act_src;
  logic [23:0] act_slot;

  int total = 0;
  int bad = 0;
  int trig_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mst_slot_table u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pkt_hdr(pkt_hdr), .upd_status(upd_status),
    .keepout(keepout), .trig_req(trig_req), .act_src(act_src),
    .act_slot(act_slot)
  );

  // behavioural reference model
  int m_ss[NE], m_sl[NE], m_as[NE], m_al[NE];
  int m_phase, m_code, m_ko, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ss[i]) begin m_ss[i] = 0; m_sl[i] = 0; m_as[i] = 0; m_al[i] = 0; end
      m_phase = 0; m_code = 0; m_ko = 0; m_cnt = 0;
    end else begin
      bit cm;
      cm = (m_phase == 2) && pkt_hdr;
      if (cm) begin m_ko = 1; m_cnt = 0; end
      else if (m_ko == 1 && pkt_hdr) begin
        m_cnt++;
        if (m_cnt == 16) begin m_ko = 0; m_cnt = 0; end
      end
      if (cm) begin
        foreach (m_as[i]) begin m_as[i] = m_ss[i]; m_al[i] = m_sl[i]; end
        m_phase = 0; m_code = 0;
      end else if (m_phase == 1) m_phase = 2;
      else if (m_phase == 0 && wr_en && wr_addr == 2'd2) begin
        if (wr_data[1:0] == 2'd1) begin m_phase = 1; m_code = 1; end
        else if (wr_data[1:0] == 2'd2) begin m_phase = 2; m_code = 2; end
      end
      if (wr_en && wr_addr < 2'd2) begin
        for (int h = 0; h < 2; h++) begin
          m_ss[wr_addr*2+h] = int'((wr_data >> (16*h)) & 32'hF);
          m_sl[wr_addr*2+h] = int'((wr_data >> (16*h+8)) & 32'h3F);
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pk_src(int a, int b, int c, int d);
    return a | (b << SW) | (c << (2*SW)) | (d << (3*SW));
  endfunction
  function automatic int pk_slot(int a, int b, int c, int d);
    return a | (b << LW) | (c << (2*LW)) | (d << (3*LW));
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R4 act_src model", int'(act_src), pk_src(m_as[0], m_as[1], m_as[2], m_as[3]));
      chk("R4 act_slot model", int'(act_slot), pk_slot(m_al[0], m_al[1], m_al[2], m_al[3]));
      chk("R3 upd_status model", int'(upd_status), m_code);
      chk("R8 keepout model", int'(keepout), m_ko);
      chk("R3 trig_req model", int'(trig_req), int'(m_phase == 1));
      if (trig_req) trig_seen++;
    end
  end

  task automatic cyc(bit we, logic [1:0] a, logic [31:0] d, bit h);
    wr_en = we; wr_addr = a; wr_data = d; pkt_hdr = h;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; pkt_hdr = 1'b0;
  endtask

  function automatic logic [31:0] word(int s0, int l0, int s1, int l1);
    return 32'(s0 | (l0 << 8) | (s1 << 16) | (l1 << 24));
  endfunction

  task automatic summary();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int tseen;
    @(negedge clk); @(negedge clk);
    chk("R1 reset act_src", int'(act_src), 0);
    chk("R1 reset keepout", int'(keepout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset upd", int'(upd_status), 0);
    chk("R1 after reset trig", int'(trig_req), 0);
    chk("R1 after reset act_slot", int'(act_slot), 0);

    // R2 staging, active untouched
    cyc(1, 2'd0, word(5, 20, 3, 10), 0);
    cyc(1, 2'd1, word(7, 33, 0, 0), 0);
    cyc(0, 0, 0, 1);
    chk("R2 staging leaves active", int'(act_src), 0);

    // R3 trigger update
    cyc(1, 2'd2, 32'd1, 0);
    chk("R3 trig high", int'(trig_req), 1);
    chk("R3 upd reads 1", int'(upd_status), 1);
    cyc(0, 0, 0, 1);
    chk("R4 header in trig cycle no commit", int'(act_src), 0);
    chk("R3 trig one cycle", int'(trig_req), 0);
    cyc(1, 2'd2, 32'd2, 0);
    chk("R7 pending write ignored", int'(upd_status), 1);
    chk("R7 no extra trig", int'(trig_req), 0);
    cyc(0, 0, 0, 1);
    chk("R4 commit src", int'(act_src), pk_src(5, 3, 7, 0));
    chk("R4 commit slot", int'(act_slot), pk_slot(20, 10, 33, 0));
    chk("R4 upd cleared", int'(upd_status), 0);
    chk("R8 keepout rises", int'(keepout), 1);

    // R8 window of 16 headers
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1);
    chk("R8 keepout after 15", int'(keepout), 1);
    cyc(0, 0, 0, 1);
    chk("R8 keepout after 16", int'(keepout), 0);

    // R5 silent update
    tseen = trig_seen;
    cyc(1, 2'd1, word(2, 9, 4, 12), 0);
    cyc(1, 2'd2, 32'd2, 0);
    chk("R5 upd reads 2", int'(upd_status), 2);
    chk("R5 no trig", int'(trig_req), 0);
    cyc(0, 0, 0, 1);
    chk("R5 commit src", int'(act_src), pk_src(5, 3, 2, 4));
    chk("R5 commit slot", int'(act_slot), pk_slot(20, 10, 9, 12));
    chk("R5 trig never seen", trig_seen, tseen);

    // R6 codes 0 and 3
    cyc(1, 2'd0, word(1, 1, 1, 1), 0);
    cyc(1, 2'd2, 32'd0, 0);
    chk("R6 code 0 upd", int'(upd_status), 0);
    cyc(1, 2'd2, 32'd3, 0);
    chk("R6 code 3 upd", int'(upd_status), 0);
    chk("R6 code 3 trig", int'(trig_req), 0);
    cyc(0, 0, 0, 1);
    chk("R6 no commit", int'(act_src), pk_src(5, 3, 2, 4));

    // R9 staging write in commit cycle
    cyc(1, 2'd0, word(6, 40, 8, 50), 0);
    cyc(1, 2'd2, 32'd2, 0);
    cyc(1, 2'd0, word(9, 11, 10, 13), 1);
    chk("R9 commit takes earlier staging", int'(act_src), pk_src(6, 8, 2, 4));
    chk("R9 commit slot earlier staging", int'(act_slot), pk_slot(40, 50, 9, 12));
    cyc(1, 2'd2, 32'd2, 0);
    cyc(0, 0, 0, 1);
    chk("R9 second commit new staging", int'(act_src), pk_src(9, 10, 2, 4));

    // R10 restart within keepout
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1);
    chk("R10 window clear", int'(keepout), 0);
    cyc(1, 2'd2, 32'd2, 0);
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1);
    cyc(1, 2'd2, 32'd2, 0);
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1);
    chk("R10 keepout restarted", int'(keepout), 1);
    cyc(0, 0, 0, 1);
    chk("R10 keepout ends at 16", int'(keepout), 0);

    @(negedge clk);
    summary();
  end
endmodule